// File: doc/BRIEF.md
# Programmable 16-bit root counter

One timer channel holds a 16-bit count, a 16-bit mode word and a 16-bit target. A small register port reads and writes all three. A parameter sets which kind of channel is built. That choice decides what the alternate clock bit in the mode word selects: an external dot-clock strobe, an external line-sync strobe, or, for the third kind, a divide-by-8 prescale together with a stop control. Each qualifying tick advances the count. The count is compared with the target and with the top of its 16-bit range.

A target match or a wrap sets sticky flags in the upper part of the mode word. Reading the mode word clears two of those flags. The interrupt enables and the repeat bit decide whether a match or wrap produces a one-cycle pulse on the interrupt request output. The interrupt controller that collects these pulses lies outside the block. In the surrounding system the three kinds of channel feed interrupt status bits 0x10, 0x20 and 0x40.

Top module: `rcnt_channel`

## Requirements
- R1: The register port selects the count at address 0, the mode word at address 1 and the target at address 2. A read strobe captures the selected value into the read-data output on the next clock edge. Address 3 reads as 0 and ignores writes. After reset every register and the read data are 0.
- R2: On a tick that is not a target reset, the count rises by one. A tick taken at 0xFFFF wraps the count to 0 and is a wrap event.
- R3: With mode bit 3 set, a tick taken while the count equals the target returns the count to 0. That tick is a target event and not a wrap event. With bit 3 clear, the same tick is still a target event and the count keeps rising.
- R4: For channel kind 0, mode bit 8 makes the count tick only on cycles where the dot strobe is high. For kind 1, mode bit 8 does the same with the line strobe. With bit 8 clear, the count ticks every clock.
- R5: For channel kind 2, mode bit 0 stops the count. Mode bit 9 gives one tick per 8 clocks, and a mode write restarts that divide phase.
- R6: Mode bit 4 enables an interrupt on target events and mode bit 5 enables one on wrap events. The interrupt request is high for the one cycle after the clock edge that takes the event.
- R7: With mode bit 6 set, every enabled event pulses the interrupt. With it clear, only the first enabled event after a mode write pulses.
- R8: A target event sets mode bits 10 and 11, and a wrap event sets bits 10 and 12. A mode read returns the word and then clears bits 11 and 12. An event in the same cycle as the read leaves its flag set.
- R9: A mode write loads bits 9..0 from the data, clears bits 15..10, clears the count and re-arms a one-shot interrupt. Bits 15..13 always read 0.
- R10: A target write leaves the count unchanged, and a tick in that cycle still compares against the old target. A count write loads the 16-bit data.
- R11: A count or mode write in a cycle overrides that cycle's tick: no advance and no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 count, 1 mode, 2 target |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| dot_tick | input | 1 | External dot-clock strobe (kind 0) |
| line_tick | input | 1 | External line-sync strobe (kind 1) |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
The assertions take for granted that a read strobe and a write strobe never fall in the same cycle. They also assume that the dot and line strobes are plain synchronous levels, sampled once per clock. The stimulus chooses at most one bus operation per cycle and drives the strobes as random per-cycle bits. It biases target values low and count loads toward 0xFFFF so that target events and wraps occur often. Three channels, one of each kind, share the same stimulus, and each is compared every cycle with its own reference model in the bench.

// File: rtl/rcnt_pkg.sv
package rcnt_pkg;
  localparam int REG_W = 16;

  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_TARGET = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  localparam int B_STOP     = 0;
  localparam int B_RST_TGT  = 3;
  localparam int B_IRQ_TGT  = 4;
  localparam int B_IRQ_WRAP = 5;
  localparam int B_REPEAT   = 6;
  localparam int B_ALT_CLK  = 8;
  localparam int B_SLOW     = 9;
  localparam int B_EVENT    = 10;
  localparam int B_HIT_TGT  = 11;
  localparam int B_HIT_WRAP = 12;

  localparam logic [REG_W-1:0] MODE_WR_MASK = 16'h03FF;
endpackage

// File: rtl/rcnt_tick_gen.sv
module rcnt_tick_gen #(
  parameter int KIND = 2,
  parameter int DIV  = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic stop_b,
  input  logic alt_b,
  input  logic slow_b,
  input  logic dot_tick,
  input  logic line_tick,
  output logic tick
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DLAST = DW'(DIV - 1);

  generate
    if (KIND == 0) begin : g_dot
      logic unused_k0;
      assign unused_k0 = ^{clk, rst, restart, stop_b, slow_b, line_tick};
      assign tick = alt_b ? dot_tick : 1'b1;
    end else if (KIND == 1) begin : g_line
      logic unused_k1;
      assign unused_k1 = ^{clk, rst, restart, stop_b, slow_b, dot_tick};
      assign tick = alt_b ? line_tick : 1'b1;
    end else begin : g_pre
      logic [DW-1:0] div_q;
      logic unused_k2;
      assign unused_k2 = ^{alt_b, dot_tick, line_tick};
      always_ff @(posedge clk) begin
        if (rst || restart)      div_q <= '0;
        else if (div_q == DLAST) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
      end
      assign tick = !stop_b && (!slow_b || (div_q == DLAST));
    end
  endgenerate
endmodule

// File: rtl/rcnt_counter.sv
module rcnt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic [W-1:0] tgt,
  input  logic         rot,
  output logic [W-1:0] cnt_q,
  output logic         tgt_ev,
  output logic         wrap_ev
);
  localparam logic [W-1:0] TOP = '1;

  logic adv, hit;
  assign adv     = tick && !clr && !ld;
  assign hit     = (cnt_q == tgt);
  assign tgt_ev  = adv && hit;
  assign wrap_ev = adv && (cnt_q == TOP) && !(rot && hit);

  always_ff @(posedge clk) begin
    if (rst || clr)       cnt_q <= '0;
    else if (ld)          cnt_q <= ld_val;
    else if (adv) begin
      if (rot && hit)     cnt_q <= '0;
      else                cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: target return
  a_r3_target_return: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !ld && rot && cnt_q == tgt) |=> (cnt_q == '0));
  // R2: plain step
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && !ld && !(rot && cnt_q == tgt)) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R9: mode write clears count
  a_r9_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt_q == '0));
endmodule

// File: rtl/rcnt_ctrl.sv
module rcnt_ctrl
  import rcnt_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic [REG_W-1:0] wdata,
  input  logic             mode_rd,
  input  logic             tgt_ev,
  input  logic             wrap_ev,
  output logic [REG_W-1:0] mode_q,
  output logic             irq_pulse
);
  logic fired_q, fire, fire_ok;

  assign fire    = (tgt_ev && mode_q[B_IRQ_TGT]) || (wrap_ev && mode_q[B_IRQ_WRAP]);
  assign fire_ok = fire && (mode_q[B_REPEAT] || !fired_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= '0;
      fired_q   <= 1'b0;
      irq_pulse <= 1'b0;
    end else if (mode_wr) begin
      mode_q    <= wdata & MODE_WR_MASK;
      fired_q   <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      if (mode_rd) begin
        mode_q[B_HIT_TGT]  <= 1'b0;
        mode_q[B_HIT_WRAP] <= 1'b0;
      end
      if (tgt_ev) begin
        mode_q[B_EVENT]   <= 1'b1;
        mode_q[B_HIT_TGT] <= 1'b1;
      end
      if (wrap_ev) begin
        mode_q[B_EVENT]    <= 1'b1;
        mode_q[B_HIT_WRAP] <= 1'b1;
      end
      irq_pulse <= fire_ok;
      if (fire_ok) fired_q <= 1'b1;
    end
  end

  // R7: a one-shot channel that already fired stays quiet
  a_r7_one_shot: assert property (@(posedge clk) disable iff (rst)
    (fired_q && !mode_q[B_REPEAT] && !mode_wr) |=> !irq_pulse);
  // R9: upper bits read zero
  a_r9_high_zero: assert property (@(posedge clk) disable iff (rst)
    mode_q[15:13] == 3'b000);
  // R8: read clears target flag when no new match
  a_r8_read_clear: assert property (@(posedge clk) disable iff (rst)
    (mode_rd && !mode_wr && !tgt_ev) |=> !mode_q[B_HIT_TGT]);
  // R6: no pulse without an enabled event
  a_r6_cause: assert property (@(posedge clk) disable iff (rst)
    (!tgt_ev && !wrap_ev) |=> !irq_pulse);
endmodule

// File: rtl/rcnt_channel.sv
module rcnt_channel
  import rcnt_pkg::*;
#(
  parameter int KIND = 2,
  parameter int DIV  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [REG_W-1:0] bus_wdata,
  output logic [REG_W-1:0] bus_rdata,
  input  logic             dot_tick,
  input  logic             line_tick,
  output logic             irq_pulse
);
  logic wr_count, wr_mode, wr_target, rd_mode, tick, tgt_ev, wrap_ev;
  logic [REG_W-1:0] cnt, mode_q, target_q;

  assign wr_count  = bus_wr && (bus_addr == SEL_COUNT);
  assign wr_mode   = bus_wr && (bus_addr == SEL_MODE);
  assign wr_target = bus_wr && (bus_addr == SEL_TARGET);
  assign rd_mode   = bus_rd && (bus_addr == SEL_MODE);

  rcnt_tick_gen #(.KIND(KIND), .DIV(DIV)) u_tick (
    .clk(clk), .rst(rst), .restart(wr_mode),
    .stop_b(mode_q[B_STOP]), .alt_b(mode_q[B_ALT_CLK]), .slow_b(mode_q[B_SLOW]),
    .dot_tick(dot_tick), .line_tick(line_tick), .tick(tick)
  );

  rcnt_counter #(.W(REG_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(wr_mode), .ld(wr_count),
    .ld_val(bus_wdata), .tgt(target_q), .rot(mode_q[B_RST_TGT]),
    .cnt_q(cnt), .tgt_ev(tgt_ev), .wrap_ev(wrap_ev)
  );

  rcnt_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_wr(wr_mode), .wdata(bus_wdata), .mode_rd(rd_mode),
    .tgt_ev(tgt_ev), .wrap_ev(wrap_ev), .mode_q(mode_q), .irq_pulse(irq_pulse)
  );

  always_ff @(posedge clk) begin
    if (rst)            target_q <= '0;
    else if (wr_target) target_q <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        SEL_COUNT:  bus_rdata <= cnt;
        SEL_MODE:   bus_rdata <= mode_q;
        SEL_TARGET: bus_rdata <= target_q;
        default:    bus_rdata <= '0;
      endcase
    end
  end

  // R10: target write leaves count alone when no tick
  a_r10_target_keep: assert property (@(posedge clk) disable iff (rst)
    (wr_target && !tick) |=> $stable(cnt));

  generate
    if (KIND == 2) begin : g_stop_chk
      // R5: stopped channel holds its count
      a_r5_halt: assert property (@(posedge clk) disable iff (rst)
        (mode_q[B_STOP] && !wr_count && !wr_mode) |=> $stable(cnt));
    end
  endgenerate
endmodule

// File: tb/tb_rcnt_channel.sv
`timescale 1ns/1ps
module tb_rcnt_channel;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic wr = 0, rd = 0, dot = 0, line = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0;
  logic [15:0] rdata [3];
  logic irq [3];

  rcnt_channel #(.KIND(2)) dut (.clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[2]), .dot_tick(dot), .line_tick(line), .irq_pulse(irq[2]));
  rcnt_channel #(.KIND(0)) dut_k0 (.clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[0]), .dot_tick(dot), .line_tick(line), .irq_pulse(irq[0]));
  rcnt_channel #(.KIND(1)) dut_k1 (.clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata[1]), .dot_tick(dot), .line_tick(line), .irq_pulse(irq[1]));

  int n_chk = 0, n_bad = 0;
  string irq_tag = "R6";

  logic [15:0] m_cnt [3], m_mode [3], m_tgt [3], m_rd [3];
  logic m_fired [3], m_irq [3];
  logic [2:0] m_div [3];

  task automatic chk(string tag, int k, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s kind%0d actual=%h expected=%h", tag, k, act, exp);
    end
  endtask

  task automatic model(int k);
    logic tk, te, we;
    logic [15:0] oc, om, ot;
    oc = m_cnt[k]; om = m_mode[k]; ot = m_tgt[k];
    case (k)
      0: tk = om[8] ? dot : 1'b1;
      1: tk = om[8] ? line : 1'b1;
      default: tk = !om[0] && (!om[9] || m_div[k] == 3'd7);
    endcase
    if (rd) begin
      case (addr)
        2'd0: m_rd[k] = oc;
        2'd1: m_rd[k] = om;
        2'd2: m_rd[k] = ot;
        default: m_rd[k] = 16'h0;
      endcase
    end
    if (wr && addr == 2'd1) begin
      m_mode[k] = wdata & 16'h03FF; m_cnt[k] = 0; m_fired[k] = 0; m_div[k] = 0; m_irq[k] = 0;
    end else begin
      m_div[k] = m_div[k] + 3'd1;
      te = 0; we = 0;
      if (wr && addr == 2'd0) m_cnt[k] = wdata;
      else if (tk) begin
        te = (oc == ot);
        if (om[3] && te) m_cnt[k] = 0;
        else begin we = (oc == 16'hFFFF); m_cnt[k] = oc + 16'd1; end
      end
      if (rd && addr == 2'd1) begin m_mode[k][11] = 0; m_mode[k][12] = 0; end
      if (te) begin m_mode[k][10] = 1; m_mode[k][11] = 1; end
      if (we) begin m_mode[k][10] = 1; m_mode[k][12] = 1; end
      m_irq[k] = ((te && om[4]) || (we && om[5])) && (om[6] || !m_fired[k]);
      if (m_irq[k]) m_fired[k] = 1;
      if (wr && addr == 2'd2) m_tgt[k] = wdata;
    end
  endtask

  task automatic step(bit w, bit r, logic [1:0] a, logic [15:0] d, bit dt, bit lt, string tag);
    wr = w; rd = r; addr = a; wdata = d; dot = dt; line = lt;
    for (int k = 0; k < 3; k++) model(k);
    @(posedge clk); #1;
    for (int k = 0; k < 3; k++) begin
      chk(irq_tag, k, {15'h0, irq[k]}, {15'h0, m_irq[k]});
      if (r) chk(tag, k, rdata[k], m_rd[k]);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1'($urandom), 1'($urandom), "R2");
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R1 watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    for (int k = 0; k < 3; k++) begin
      m_cnt[k] = 0; m_mode[k] = 0; m_tgt[k] = 0; m_rd[k] = 0;
      m_fired[k] = 0; m_irq[k] = 0; m_div[k] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst = 0;
    for (int k = 0; k < 3; k++) chk("R1", k, rdata[k], 16'h0);
    step(0, 1, 2'd1, 0, 0, 0, "R1");
    // R1: target and unused address
    step(1, 0, 2'd2, 16'h1234, 0, 0, "R1");
    step(0, 1, 2'd2, 0, 0, 0, "R1");
    step(1, 0, 2'd3, 16'hBEEF, 0, 0, "R1");
    step(0, 1, 2'd3, 0, 0, 0, "R1");
    // R9: mode write masks bits
    step(1, 0, 2'd1, 16'hFFFE, 0, 0, "R9");
    step(0, 1, 2'd1, 0, 0, 0, "R9");
    step(0, 1, 2'd0, 0, 0, 0, "R9");
    // R3 with one-shot target interrupt (R7)
    irq_tag = "R7";
    step(1, 0, 2'd2, 16'd4, 0, 0, "R3");
    step(1, 0, 2'd1, 16'h0018, 0, 0, "R3");
    idle(23);
    step(0, 1, 2'd0, 0, 0, 0, "R3");
    // R7: repeating
    step(1, 0, 2'd1, 16'h0058, 0, 0, "R7");
    idle(23);
    irq_tag = "R6";
    // R2 / R8: wrap with interrupt
    step(1, 0, 2'd1, 16'h0020, 0, 0, "R2");
    step(1, 0, 2'd0, 16'hFFFD, 0, 0, "R11");
    idle(5);
    step(0, 1, 2'd1, 0, 0, 0, "R8");
    step(0, 1, 2'd1, 0, 0, 0, "R8");
    step(0, 1, 2'd0, 0, 0, 0, "R2");
    // R4: alternate strobes
    step(1, 0, 2'd1, 16'h0100, 0, 0, "R4");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1'(i % 3 == 0), 1'(i % 5 == 0), "R4");
    step(0, 1, 2'd0, 0, 0, 0, "R4");
    // R5: slow tick then stop
    step(1, 0, 2'd1, 16'h0200, 0, 0, "R5");
    idle(30);
    step(0, 1, 2'd0, 0, 0, 0, "R5");
    step(1, 0, 2'd1, 16'h0001, 0, 0, "R5");
    idle(10);
    step(0, 1, 2'd0, 0, 0, 0, "R5");
    // R10: target write keeps count, count write loads
    step(1, 0, 2'd1, 16'h0000, 0, 0, "R10");
    idle(7);
    step(1, 0, 2'd2, 16'h0003, 0, 0, "R10");
    step(0, 1, 2'd0, 0, 0, 0, "R10");
    step(1, 0, 2'd0, 16'h7777, 0, 0, "R10");
    step(0, 1, 2'd0, 0, 0, 0, "R10");
    // R11: count write in place of a tick at the target
    step(1, 0, 2'd1, 16'h0018, 0, 0, "R11");
    step(1, 0, 2'd2, 16'd2, 0, 0, "R11");
    step(1, 0, 2'd0, 16'd2, 0, 0, "R11");
    step(1, 0, 2'd0, 16'd2, 0, 0, "R11");
    step(0, 1, 2'd1, 0, 0, 0, "R11");
    // random mix
    for (int i = 0; i < 6000; i++) begin
      int op;
      logic [1:0] a;
      logic [15:0] d;
      op = $urandom % 10;
      a = 2'($urandom);
      d = 16'($urandom);
      if (op < 6) idle(1);
      else if (op < 8) begin
        string t;
        case (a)
          2'd0: t = "R2";
          2'd1: t = "R8";
          2'd2: t = "R10";
          default: t = "R1";
        endcase
        step(0, 1, a, 0, 1'($urandom), 1'($urandom), t);
      end else begin
        if (a == 2'd0 && ($urandom % 3 == 0)) d = 16'hFFF0 | 16'($urandom % 16);
        if (a == 2'd1 && ($urandom % 4 != 0)) d[0] = 1'b0;
        if (a == 2'd2) d = 16'($urandom % 40);
        step(1, 0, a, d, 1'($urandom), 1'($urandom), "R9");
      end
    end
    summary();
  end
endmodule